// File: doc/BRIEF.md
# Page Half-Line Swap Engine

This block repairs the contents of one 4096-byte page after the page has moved to a new physical frame. The block keeps one saved bit per page. If the new frame's address bit 17 differs from the saved bit, every 128-byte span of the page has its two 64-byte halves exchanged. The page sits in an external dual-port buffer of 64-bit words. The read port returns data one cycle after a read request. The write port takes effect at the clock edge.

A request is a one-cycle `start` with a page index, the current bit 17, a mode and a bitmap-present flag. In save mode the engine stores the current bit 17 into the page's bitmap entry and does not touch the buffer. In restore mode the engine compares the current bit with the stored one and swaps the page only if they differ. It then marks the page dirty and pulses `done`.

The controller is a state machine with these states:
- `ST_IDLE` waits for `start`. From it, a save request, a restore with no bitmap, or a restore with matching bits goes to `ST_FINISH`. A restore with mismatching bits goes to `ST_LOAD_LO`.
- `ST_LOAD_LO` reads the eight lower-half words of a span into a temporary register file and then goes to `ST_MOVE_HI`.
- `ST_MOVE_HI` reads the eight upper-half words. Each word is written to the matching lower-half address one cycle later. The state then goes to `ST_STORE_HI`.
- `ST_STORE_HI` writes the eight saved words into the upper half. It goes back to `ST_LOAD_LO` for the next span, or to `ST_DRAIN` after the last span.
- `ST_DRAIN` completes the final write and goes to `ST_FINISH`.
- `ST_FINISH` drives `done` for one cycle and returns to `ST_IDLE`.

Top module: `page_half_swap`

## Requirements
- R1: In a swap, the 64-bit word at buffer address s*16+w is exchanged with the word at s*16+8+w, for every span s in 0..31 and word w in 0..7. The byte offset of a word is its address times 8.
- R2: A restore with `map_valid`=1 swaps only when `phys_b17` differs from the saved bit for `page_idx`. Otherwise it makes no buffer read or write, and the buffer is unchanged.
- R3: `dirty` is 0 after reset. It is set in the cycle after a start that leads to a swap, and cleared in the cycle after any other accepted start. It holds its value until the next accepted start.
- R4: A restore with `map_valid`=0 makes no buffer access and raises `done` in the cycle after the start edge.
- R5: Save mode (`mode_save`=1) writes `phys_b17` into the bitmap bit chosen by `page_idx` (0..255), both when setting it to 1 and when clearing it to 0. It makes no buffer access and raises `done` in the cycle after the start edge.
- R6: A swap raises `done` 770 cycles after the start edge and makes exactly 512 reads and 512 writes. `done` is high for exactly one cycle.
- R7: A `start` that arrives while `busy` is 1 is ignored, including its mode and page index.
- R8: After reset the bitmap is all zero, `busy`, `done` and `dirty` are 0, and no buffer port is active while the engine is idle.
- R9: The bitmap bits of different pages are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| mode_save | input | 1 | 1 = record bit 17, 0 = restore (conditional swap) |
| page_idx | input | 8 | Page number that selects the bitmap bit |
| phys_b17 | input | 1 | Current physical address bit 17 of the page |
| map_valid | input | 1 | Bitmap has been allocated |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | 9 | Buffer read word address |
| buf_rd_data | input | 64 | Read data, one cycle after the request |
| buf_wr_en | output | 1 | Buffer write enable |
| buf_wr_addr | output | 9 | Buffer write word address |
| buf_wr_data | output | 64 | Buffer write data |
| busy | output | 1 | Engine not idle |
| dirty | output | 1 | Last accepted request swapped the page |
| done | output | 1 | Completion pulse |

## Verification
Some rules are checked on every cycle:
- no buffer activity while idle;
- each lower-half write follows a read in the previous cycle;
- save and bitmap-less restore finish in one cycle;
- `done` lasts one cycle;
- `busy` cannot drop before `done`;
- `dirty` holds between requests.

Other behaviour is shown only by the bench scenarios, which compare the whole buffer against a model after each request:
- that the data really lands in the swapped positions;
- that the bitmap remembers each page's bit independently;
- that a start while busy does not change the bitmap.

// File: rtl/phs_pkg.sv
package phs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_LO,
        ST_MOVE_HI,
        ST_STORE_HI,
        ST_DRAIN,
        ST_FINISH
    } phs_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CAPTURE,
        OP_MOVE,
        OP_STORE
    } phs_op_e;
endpackage

// File: rtl/phs_bitmap.sv
module phs_bitmap #(
    parameter int PAGES = 256,
    parameter int PG_W  = $clog2(PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_idx,
    input  logic            wr_val,
    input  logic [PG_W-1:0] rd_idx,
    output logic            rd_bit
);
    logic [PAGES-1:0] bits_q;

    for (genvar g = 0; g < PAGES; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PG_W'(g))) begin
                bits_q[g] <= wr_val;
            end
        end
    end

    assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/phs_stash.sv
module phs_stash #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_ptr];
endmodule

// File: rtl/phs_ctrl.sv
module phs_ctrl
    import phs_pkg::*;
#(
    parameter int SPAN_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_save,
    input  logic              map_valid,
    input  logic              mismatch,
    output phs_state_e        state,
    output phs_op_e           op_kind,
    output logic [IDX_W-1:0]  op_idx,
    output logic [SPAN_W-1:0] op_span,
    output logic              accept,
    output logic              dirty
);
    localparam logic [IDX_W-1:0]  IDX_LAST  = '1;
    localparam logic [SPAN_W-1:0] SPAN_LAST = '1;

    phs_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [SPAN_W-1:0] span_q;
    logic              dirty_q;
    logic              go_swap;

    assign accept  = start && (state_q == ST_IDLE);
    assign go_swap = !mode_save && map_valid && mismatch;

    // state register with word and span counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            span_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dirty_q <= go_swap;
            end
            unique case (state_q)
                ST_LOAD_LO, ST_MOVE_HI: begin
                    idx_q <= idx_q + 1'b1;
                end
                ST_STORE_HI: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        span_q <= span_q + 1'b1;
                    end
                end
                default: begin
                    idx_q  <= '0;
                    span_q <= '0;
                end
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = go_swap ? ST_LOAD_LO : ST_FINISH;
                end
            end
            ST_LOAD_LO: begin
                if (idx_q == IDX_LAST) state_d = ST_MOVE_HI;
            end
            ST_MOVE_HI: begin
                if (idx_q == IDX_LAST) state_d = ST_STORE_HI;
            end
            ST_STORE_HI: begin
                if (idx_q == IDX_LAST) begin
                    state_d = (span_q == SPAN_LAST) ? ST_DRAIN : ST_LOAD_LO;
                end
            end
            ST_DRAIN:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        op_kind = OP_NONE;
        unique case (state_q)
            ST_LOAD_LO:  op_kind = OP_CAPTURE;
            ST_MOVE_HI:  op_kind = OP_MOVE;
            ST_STORE_HI: op_kind = OP_STORE;
            default:     op_kind = OP_NONE;
        endcase
    end

    assign state   = state_q;
    assign op_idx  = idx_q;
    assign op_span = span_q;
    assign dirty   = dirty_q;
endmodule

// File: rtl/page_half_swap.sv
module page_half_swap
    import phs_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int SPAN_BYTES = 128,
    parameter int WORD_BYTES = 8,
    parameter int MAP_PAGES  = 256,
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int HALF_WORDS = SPAN_BYTES / (2 * WORD_BYTES),
    localparam int SPANS      = PAGE_BYTES / SPAN_BYTES,
    localparam int IDX_W      = $clog2(HALF_WORDS),
    localparam int SPAN_W     = $clog2(SPANS),
    localparam int ADDR_W     = SPAN_W + 1 + IDX_W,
    localparam int PG_W       = $clog2(MAP_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_save,
    input  logic [PG_W-1:0]   page_idx,
    input  logic              phys_b17,
    input  logic              map_valid,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [WORD_W-1:0] buf_rd_data,
    output logic              buf_wr_en,
    output logic [ADDR_W-1:0] buf_wr_addr,
    output logic [WORD_W-1:0] buf_wr_data,
    output logic              busy,
    output logic              dirty,
    output logic              done
);
    phs_state_e        state;
    phs_op_e           op_kind;
    logic [IDX_W-1:0]  op_idx;
    logic [SPAN_W-1:0] op_span;
    logic              accept;
    logic              saved_bit;

    // write-stage registers: one issued operation in flight
    phs_op_e           p_op;
    logic [IDX_W-1:0]  p_idx;
    logic [SPAN_W-1:0] p_span;
    logic [WORD_W-1:0] stash_word;

    phs_bitmap #(.PAGES(MAP_PAGES), .PG_W(PG_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept && mode_save),
        .wr_idx (page_idx),
        .wr_val (phys_b17),
        .rd_idx (page_idx),
        .rd_bit (saved_bit)
    );

    phs_ctrl #(.SPAN_W(SPAN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_save (mode_save),
        .map_valid (map_valid),
        .mismatch  (phys_b17 ^ saved_bit),
        .state     (state),
        .op_kind   (op_kind),
        .op_idx    (op_idx),
        .op_span   (op_span),
        .accept    (accept),
        .dirty     (dirty)
    );

    phs_stash #(.DEPTH(HALF_WORDS), .WIDTH(WORD_W), .PTR_W(IDX_W)) u_stash (
        .clk     (clk),
        .wr_en   (p_op == OP_CAPTURE),
        .wr_ptr  (p_idx),
        .wr_data (buf_rd_data),
        .rd_ptr  (p_idx),
        .rd_data (stash_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_op   <= OP_NONE;
            p_idx  <= '0;
            p_span <= '0;
        end else begin
            p_op   <= op_kind;
            p_idx  <= op_idx;
            p_span <= op_span;
        end
    end

    always_comb begin
        buf_rd_en   = (op_kind == OP_CAPTURE) || (op_kind == OP_MOVE);
        buf_rd_addr = {op_span, (op_kind == OP_MOVE), op_idx};
        buf_wr_en   = (p_op == OP_MOVE) || (p_op == OP_STORE);
        buf_wr_addr = {p_span, (p_op == OP_STORE), p_idx};
        buf_wr_data = (p_op == OP_MOVE) ? buf_rd_data : stash_word;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
    end
endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
    parameter int ADDR_W   = 9,
    parameter int HALF_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mode_save,
    input logic              map_valid,
    input logic              busy,
    input logic              dirty,
    input logic              done,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic [ADDR_W-1:0] buf_wr_addr
);
    AST_LOW_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en && !buf_wr_addr[HALF_BIT] |-> $past(buf_rd_en)); // R1
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !buf_wr_en && !buf_rd_en); // R8
    AST_DIRTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(dirty)); // R3
    AST_NOMAP_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !mode_save && !map_valid |=> done && !dirty); // R4
    AST_SAVE_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && mode_save |=> done && !dirty); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R7
endmodule

bind page_half_swap phs_checker #(.ADDR_W(ADDR_W), .HALF_BIT(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_save   (mode_save),
    .map_valid   (map_valid),
    .busy        (busy),
    .dirty       (dirty),
    .done        (done),
    .buf_rd_en   (buf_rd_en),
    .buf_wr_en   (buf_wr_en),
    .buf_wr_addr (buf_wr_addr)
);

// File: tb/sim_page_half_swap.sv
module sim_page_half_swap;
    localparam int WORDS    = 512;
    localparam int SWAP_LAT = 770;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_save = 1'b0;
    logic [7:0]  page_idx = '0;
    logic        phys_b17 = 1'b0;
    logic        map_valid = 1'b0;
    logic        buf_rd_en, buf_wr_en, busy, dirty, done;
    logic [8:0]  buf_rd_addr, buf_wr_addr;
    logic [63:0] buf_rd_data, buf_wr_data;

    logic        tb_we = 1'b0;
    logic [8:0]  tb_addr = '0;
    logic [63:0] tb_data = '0;
    logic [63:0] mem [WORDS];
    logic [63:0] exp_mem [WORDS];
    bit          model_map [256];

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int done_cnt = 0;

    always #10 clk = ~clk;

    page_half_swap u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_save(mode_save),
        .page_idx(page_idx), .phys_b17(phys_b17), .map_valid(map_valid),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .busy(busy), .dirty(dirty), .done(done)
    );

    always_ff @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
        if (buf_wr_en) mem[buf_wr_addr] <= buf_wr_data;
        else if (tb_we) mem[tb_addr] <= tb_data;
    end

    always @(posedge clk) begin
        if (buf_rd_en) acc_cnt <= acc_cnt + 1;
        if (buf_wr_en) acc_cnt <= acc_cnt + 1 + (buf_rd_en ? 1 : 0);
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit wants_swap(bit sv, int pg, bit b, bit mv);
        return !sv && mv && (b != model_map[pg]);
    endfunction

    task automatic model_swap();
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 8; w++) begin
                logic [63:0] t;
                t = exp_mem[s*16+w];
                exp_mem[s*16+w] = exp_mem[s*16+8+w];
                exp_mem[s*16+8+w] = t;
            end
        end
    endtask

    task automatic fill_mem();
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            tb_we = 1'b1; tb_addr = 9'(a); tb_data = {$urandom(), $urandom()};
            exp_mem[a] = tb_data;
        end
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < WORDS; a++) begin
            if (mem[a] !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, req, bad, 0);
        if (bad != 0) $display("  first mismatching word address %0d", first);
    endtask

    // issue one request and check every visible outcome against the model
    task automatic do_op(input bit sv, input int pg, input bit b, input bit mv, input string tag);
        int lat = 1;
        int acc0;
        bit sw;
        sw = wants_swap(sv, pg, b, mv);
        acc0 = acc_cnt;
        @(negedge clk);
        mode_save = sv; page_idx = 8'(pg); phys_b17 = b; map_valid = mv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        if (sv) model_map[pg] = b;
        if (sw) model_swap();
        chk(lat == (sw ? SWAP_LAT : 1), sw ? {tag, " R6 latency"} : (sv ? {tag, " R5 latency"} : {tag, " R4/R2 latency"}),
            lat, sw ? SWAP_LAT : 1);
        chk(dirty == sw, {tag, " R3 dirty"}, dirty, sw);
        chk((acc_cnt - acc0) == (sw ? 1024 : 0), {tag, " R2/R4/R5 access count"}, acc_cnt - acc0, sw ? 1024 : 0);
        cmp_mem({tag, " R1/R2 buffer"});
        @(negedge clk);
        chk(!done, {tag, " R6 done single"}, done, 0);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!busy, "R8 busy", busy, 0);
        chk(!done, "R8 done", done, 0);
        chk(!dirty, "R8 dirty", dirty, 0);
        chk(!buf_wr_en && !buf_rd_en, "R8 ports idle", buf_wr_en, 0);
        rst_n = 1'b1;
        fill_mem();

        do_op(0, 5, 0, 1, "restore match after reset R8 R2");
        do_op(0, 5, 1, 0, "no bitmap R4");
        do_op(0, 5, 1, 1, "restore mismatch R1");
        do_op(0, 0, 1, 1, "page 0 swap R1");
        do_op(1, 5, 1, 1, "save one R5");
        do_op(0, 5, 1, 1, "restore after save R5");
        do_op(0, 6, 1, 1, "neighbour page R9");
        do_op(1, 255, 1, 0, "save top page R5");
        do_op(0, 255, 1, 1, "top page match R9");
        do_op(0, 254, 1, 1, "page below top R9");
        do_op(1, 5, 0, 1, "save zero R5");
        do_op(0, 5, 1, 1, "restore after clear R5");

        // R7: start while busy is ignored
        begin
            int d0;
            int lat = 1;
            d0 = done_cnt;
            @(negedge clk);
            mode_save = 0; page_idx = 8'd9; phys_b17 = 1; map_valid = 1; start = 1;
            @(negedge clk);
            start = 0;
            repeat (99) begin @(negedge clk); lat++; end
            mode_save = 1; page_idx = 8'd7; phys_b17 = 1; start = 1;
            @(negedge clk);
            start = 0; lat++;
            while (!done && lat < 2000) begin @(negedge clk); lat++; end
            model_swap();
            chk(lat == SWAP_LAT, "R7 latency with busy start", lat, SWAP_LAT);
            @(negedge clk);
            chk(done_cnt - d0 == 1, "R7 single completion", done_cnt - d0, 1);
            cmp_mem("R7 buffer");
            do_op(0, 7, 0, 1, "R7 bitmap untouched");
        end

        // random mix
        for (int i = 0; i < 24; i++) begin
            bit sv, b, mv;
            int pg;
            sv = ($urandom() % 3) == 0;
            mv = ($urandom() % 5) != 0;
            b  = 1'($urandom());
            pg = int'($urandom() % 256);
            do_op(sv, pg, b, mv, "random R2 R5 R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule